// File: doc/BRIEF.md
# Program Counter Branch Sequencer

This block produces the instruction address of a Harvard RISC core that issues one 16-bit instruction per cycle. Every clock edge it picks the next program-counter value from a decoded branch-kind code supplied by the instruction decoder: step to the following word, jump to a target, jump only when the carry or zero flag is in the requested state, enter a subroutine, leave a subroutine, or stop. The counter covers the 2048 word addresses of a 4 KByte program store and starts from word 0 after reset.

Subroutine entry saves the address of the word after the call in a small internal last-in first-out return store; subroutine exit restores the most recent saved address. Pushing onto a full store or popping an empty one leaves the store untouched and sets an error flag that stays set until reset. A stop command freezes the counter, and only reset resumes execution.

Top module: `pcseq_top`

## Requirements
- R1: During reset (rst_n low at a clock edge) the counter is set to 0, the halted and error outputs clear and the return store becomes empty; a return issued as the first command after reset therefore counts as an empty-store return.
- R2: Kind code 0 (step) loads PC+1; the counter is 11 bits wide and wraps from 2047 to 0.
- R3: Kind code 1 (jump) loads the target address regardless of the flags.
- R4: Kind codes 2 (carry set), 3 (carry clear), 4 (zero set) and 5 (zero clear) load the target when the named flag is in the named state.
- R5: A conditional kind whose condition is false loads PC+1.
- R6: Kind code 6 (call) loads the target and saves PC+1 in the return store.
- R7: Kind code 7 (return) loads the most recently saved address and removes it; saved addresses come back in reverse order of saving.
- R8: The return store holds 8 addresses; a call while it is full still loads the target, leaves the store contents unchanged and sets the error flag.
- R9: A return while the store is empty loads PC+1, leaves the store empty and sets the error flag.
- R10: The error flag, once set, stays set under any command until reset.
- R11: Kind code 8 (halt) keeps the counter at its present value and raises the halted output from the next cycle; while halted every command is ignored (counter, store and error flag unchanged) until reset.
- R12: Kind codes 9 to 15 behave as step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| br_kind | input | 4 | Decoded branch-kind code for the current instruction |
| br_target | input | 11 | Target word address for jumps and calls |
| flag_c | input | 1 | Current carry flag |
| flag_z | input | 1 | Current zero flag |
| pc_q | output | 11 | Current program-counter value |
| halted | output | 1 | High once a halt has been taken |
| stack_err | output | 1 | Sticky return-store overflow/underflow flag |

## Verification
The assertions assume the branch-kind code, target and flags are valid (not X) at every rising edge once reset is released, and that reset is held for at least one edge before the first command. The stimulus honours this by driving every input from the falling edge, setting them to defined values before reset is released, and holding reset low across two rising edges. Unused kind codes are driven on purpose, since the block defines them as step.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    BK_STEP = 4'd0,
    BK_JUMP = 4'd1,
    BK_JC   = 4'd2,
    BK_JNC  = 4'd3,
    BK_JZ   = 4'd4,
    BK_JNZ  = 4'd5,
    BK_CALL = 4'd6,
    BK_RET  = 4'd7,
    BK_HALT = 4'd8
  } br_kind_e;

  // True for the four flag-conditioned jump kinds.
  function automatic logic kind_is_cond(input logic [KIND_W-1:0] k);
    return (k == BK_JC) || (k == BK_JNC) || (k == BK_JZ) || (k == BK_JNZ);
  endfunction

  // Flag test for a conditional kind; false for any other kind.
  function automatic logic cond_holds(input logic [KIND_W-1:0] k,
                                      input logic c, input logic z);
    logic r;
    case (k)
      BK_JC:   r = c;
      BK_JNC:  r = !c;
      BK_JZ:   r = z;
      BK_JNZ:  r = !z;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pcseq_cond.sv
module pcseq_cond
  import pcseq_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  input  logic              flag_c,
  input  logic              flag_z,
  output logic              is_cond,
  output logic              taken
);

  always_comb begin
    is_cond = kind_is_cond(kind);
    taken   = cond_holds(kind, flag_c, flag_z);
  end

endmodule

// File: rtl/pcseq_ras.sv
module pcseq_ras #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  logic                        pop,
  input  logic [DATA_W-1:0]           push_data,
  output logic [DATA_W-1:0]           top_data,
  output logic                        full,
  output logic                        empty,
  output logic [$clog2(DEPTH+1)-1:0]  count,
  output logic                        ovf_evt,
  output logic                        unf_evt
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push;
  logic              do_pop;
  logic [IDX_W-1:0]  wr_idx;
  logic [IDX_W-1:0]  rd_idx;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign ovf_evt = push && full;
  assign unf_evt = pop && empty;
  assign wr_idx  = IDX_W'(cnt_q);
  assign rd_idx  = IDX_W'(cnt_q - 1'b1);
  assign top_data = slot_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (do_push) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (do_pop) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (do_push && (wr_idx == IDX_W'(g))) begin
          slot_q[g] <= push_data;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int RAS_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        br_kind,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              flag_c,
  input  logic              flag_z,
  output logic [ADDR_W-1:0] pc_q,
  output logic              halted,
  output logic              stack_err
);

  localparam int CNT_W = $clog2(RAS_DEPTH + 1);

  logic [ADDR_W-1:0] pc_r;
  logic              halt_r;
  logic              err_r;

  // Named internal events, visible to the checker.
  logic              active;
  logic              is_cond;
  logic              cond_taken;
  logic              ev_call;
  logic              ev_ret;
  logic              ev_halt;
  logic              ev_ovf;
  logic              ev_unf;
  logic [ADDR_W-1:0] pc_inc;
  logic [ADDR_W-1:0] ras_top;
  logic              ras_full;
  logic              ras_empty;
  logic [CNT_W-1:0]  ras_count;
  logic [ADDR_W-1:0] pc_next;

  function automatic logic [ADDR_W-1:0] pick_next(
    input logic [KIND_W-1:0] k,
    input logic [ADDR_W-1:0] cur,
    input logic [ADDR_W-1:0] tgt,
    input logic              take,
    input logic [ADDR_W-1:0] top,
    input logic              stk_empty
  );
    logic [ADDR_W-1:0] seq;
    logic [ADDR_W-1:0] r;
    seq = cur + 1'b1;
    case (k)
      BK_JUMP, BK_CALL:             r = tgt;
      BK_JC, BK_JNC, BK_JZ, BK_JNZ: r = take ? tgt : seq;
      BK_RET:                       r = stk_empty ? seq : top;
      BK_HALT:                      r = cur;
      default:                      r = seq;
    endcase
    return r;
  endfunction

  assign active  = !halt_r;
  assign pc_inc  = pc_r + 1'b1;
  assign ev_call = active && (br_kind == BK_CALL);
  assign ev_ret  = active && (br_kind == BK_RET);
  assign ev_halt = active && (br_kind == BK_HALT);

  pcseq_cond u_cond (
    .kind    (br_kind),
    .flag_c  (flag_c),
    .flag_z  (flag_z),
    .is_cond (is_cond),
    .taken   (cond_taken)
  );

  pcseq_ras #(
    .DEPTH  (RAS_DEPTH),
    .DATA_W (ADDR_W)
  ) u_ras (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_call),
    .pop       (ev_ret),
    .push_data (pc_inc),
    .top_data  (ras_top),
    .full      (ras_full),
    .empty     (ras_empty),
    .count     (ras_count),
    .ovf_evt   (ev_ovf),
    .unf_evt   (ev_unf)
  );

  assign pc_next = pick_next(br_kind, pc_r, br_target, is_cond && cond_taken,
                             ras_top, ras_empty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_r   <= '0;
      halt_r <= 1'b0;
      err_r  <= 1'b0;
    end else if (active) begin
      pc_r <= pc_next;
      if (ev_halt) halt_r <= 1'b1;
      if (ev_ovf || ev_unf) err_r <= 1'b1;
    end
  end

  assign pc_q      = pc_r;
  assign halted    = halt_r;
  assign stack_err = err_r;

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk
  import pcseq_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int RAS_DEPTH = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [3:0]                     br_kind,
  input logic [ADDR_W-1:0]              br_target,
  input logic                           flag_c,
  input logic                           flag_z,
  input logic [ADDR_W-1:0]              pc_q,
  input logic                           halted,
  input logic                           stack_err,
  input logic [$clog2(RAS_DEPTH+1)-1:0] ras_count
);

  localparam int CNT_W = $clog2(RAS_DEPTH + 1);

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |=> (pc_q == '0) && !halted && !stack_err && (ras_count == '0)); // R1

  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && br_kind == BK_STEP) |=> pc_q == ADDR_W'($past(pc_q) + 1'b1)); // R2

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && br_kind == BK_JUMP) |=> pc_q == $past(br_target)); // R3

  AST_CARRY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && br_kind == BK_JC && flag_c) |=> pc_q == $past(br_target)); // R4

  AST_ZERO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && br_kind == BK_JNZ && flag_z) |=> pc_q == ADDR_W'($past(pc_q) + 1'b1)); // R5

  AST_CALL_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && br_kind == BK_CALL && ras_count < CNT_W'(RAS_DEPTH))
      |=> ras_count == CNT_W'($past(ras_count) + 1'b1)); // R6

  AST_STACK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ras_count <= CNT_W'(RAS_DEPTH)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && br_kind == BK_CALL && ras_count == CNT_W'(RAS_DEPTH))
      |=> stack_err && ras_count == CNT_W'(RAS_DEPTH) && pc_q == $past(br_target)); // R8

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && br_kind == BK_RET && ras_count == '0)
      |=> stack_err && ras_count == '0 && pc_q == ADDR_W'($past(pc_q) + 1'b1)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err); // R10

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc_q) && $stable(ras_count) && $stable(stack_err)); // R11

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && br_kind == BK_HALT) |=> halted && $stable(pc_q)); // R11

endmodule

bind pcseq_top pcseq_chk #(
  .ADDR_W    (ADDR_W),
  .RAS_DEPTH (RAS_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .br_kind   (br_kind),
  .br_target (br_target),
  .flag_c    (flag_c),
  .flag_z    (flag_z),
  .pc_q      (pc_q),
  .halted    (halted),
  .stack_err (stack_err),
  .ras_count (ras_count)
);

// File: tb/sim_pcseq_top.sv
module sim_pcseq_top;

  localparam int AW = 11;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    br_kind = 4'd0;
  logic [AW-1:0] br_target = '0;
  logic          flag_c = 1'b0;
  logic          flag_z = 1'b0;
  logic [AW-1:0] pc_q;
  logic          halted;
  logic          stack_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench-side reference state
  logic [AW-1:0] m_pc;
  logic          m_halt;
  logic          m_err;
  logic [AW-1:0] m_stk [DEPTH];
  int            m_cnt;

  always #5 clk = ~clk;

  pcseq_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .br_kind   (br_kind),
    .br_target (br_target),
    .flag_c    (flag_c),
    .flag_z    (flag_z),
    .pc_q      (pc_q),
    .halted    (halted),
    .stack_err (stack_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(pc_q == m_pc, tag, int'(pc_q), int'(m_pc));
    check(halted == m_halt, tag, int'(halted), int'(m_halt));
    check(stack_err == m_err, tag, int'(stack_err), int'(m_err));
  endtask

  function automatic string tag_of(input logic [3:0] k, input logic c, input logic z);
    case (k)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return c ? "R4" : "R5";
      4'd3: return !c ? "R4" : "R5";
      4'd4: return z ? "R4" : "R5";
      4'd5: return !z ? "R4" : "R5";
      4'd6: return (m_cnt < DEPTH) ? "R6" : "R8";
      4'd7: return (m_cnt > 0) ? "R7" : "R9";
      4'd8: return "R11";
      default: return "R12";
    endcase
  endfunction

  // Reference next state, computed from the requirement text.
  task automatic model_edge(input logic [3:0] k, input logic [AW-1:0] t,
                            input logic c, input logic z);
    logic [AW-1:0] seq;
    if (m_halt) return;
    seq = m_pc + 11'd1;
    case (k)
      4'd1: m_pc = t;
      4'd2: m_pc = (c == 1'b1) ? t : seq;
      4'd3: m_pc = (c == 1'b0) ? t : seq;
      4'd4: m_pc = (z == 1'b1) ? t : seq;
      4'd5: m_pc = (z == 1'b0) ? t : seq;
      4'd6: begin
        if (m_cnt < DEPTH) begin
          m_stk[m_cnt] = seq;
          m_cnt++;
        end else begin
          m_err = 1'b1;
        end
        m_pc = t;
      end
      4'd7: begin
        if (m_cnt > 0) begin
          m_cnt--;
          m_pc = m_stk[m_cnt];
        end else begin
          m_err = 1'b1;
          m_pc = seq;
        end
      end
      4'd8: m_halt = 1'b1;
      default: m_pc = seq;
    endcase
  endtask

  // Called at a falling edge; returns at the following falling edge.
  task automatic step(input logic [3:0] k, input logic [AW-1:0] t,
                      input logic c, input logic z);
    string tag;
    tag = tag_of(k, c, z);
    br_kind = k;
    br_target = t;
    flag_c = c;
    flag_z = z;
    @(posedge clk);
    model_edge(k, t, c, z);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    br_kind = 4'd1;
    br_target = 11'd1234;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_pc = '0;
    m_halt = 1'b0;
    m_err = 1'b0;
    m_cnt = 0;
    check_all("R1");
  endtask

  initial begin
    do_reset();

    // R1: store empty after reset, so a first return underflows (R9)
    step(4'd7, 11'd55, 1'b0, 1'b0);
    check(pc_q == 11'd1 && stack_err, "R1", int'(pc_q), 1);

    // R10: error stays across many other commands
    for (int i = 0; i < 6; i++) begin
      step(4'(i % 6), 11'(i * 91), 1'(i & 1), 1'(i >> 1));
      check(stack_err == 1'b1, "R10", int'(stack_err), 1);
    end
    do_reset();

    // Sweep every non-halt kind under every flag pair
    for (int k = 0; k < 16; k++) begin
      if (k == 8) continue;
      for (int f = 0; f < 4; f++) begin
        step(4'(k), 11'((k * 317 + f * 53 + 7) % 2048), 1'(f & 1), 1'(f >> 1));
      end
    end
    do_reset();

    // R2: wrap from the top address
    step(4'd1, 11'd2047, 1'b0, 1'b0);
    step(4'd0, 11'd5, 1'b0, 1'b0);
    check(pc_q == 11'd0, "R2", int'(pc_q), 0);

    // R6/R7/R8: nested calls beyond capacity, then unwind in reverse order
    for (int i = 0; i < DEPTH + 1; i++) begin
      step(4'd6, 11'(100 + i * 40), 1'b0, 1'b0);
    end
    check(stack_err == 1'b1, "R8", int'(stack_err), 1);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      step(4'd7, 11'd0, 1'b0, 1'b0);
      // return address of the i-th call: previous call target + 1 (first: 1)
      check(pc_q == ((i == 0) ? 11'd1 : 11'(100 + (i - 1) * 40 + 1)), "R7",
            int'(pc_q), (i == 0) ? 1 : 100 + (i - 1) * 40 + 1);
    end
    step(4'd7, 11'd0, 1'b0, 1'b0);
    do_reset();

    // R11: halt, then every command ignored until reset
    step(4'd1, 11'd700, 1'b0, 1'b0);
    step(4'd6, 11'd900, 1'b0, 1'b0);
    step(4'd8, 11'd3, 1'b1, 1'b1);
    check(halted && pc_q == 11'd900, "R11", int'(pc_q), 900);
    for (int k = 0; k < 16; k++) begin
      step(4'(k), 11'(k * 13), 1'(k & 1), 1'b1);
    end
    check(!stack_err, "R11", int'(stack_err), 0);
    do_reset();
    // after reset the store is empty again even though a call was pending
    step(4'd7, 11'd0, 1'b0, 1'b0);
    check(pc_q == 11'd1 && stack_err, "R1", int'(pc_q), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule